// File: doc/BRIEF.md
# Single-Wire Identifier Slave

This block is the slave end of a single-wire, open-drain serial bus for a device whose only content is a fixed 64-bit identifier. It watches an oversampled copy of the bus line. When the master holds the line low long enough to mean a reset, the block answers with a presence pulse. It then reads one 8-bit command. The block either sends its identifier in full or takes part in the bitwise search by which a master finds every device on a shared line. Any other command leaves it silent until the next reset.

The identifier has three parts: an 8-bit family code, a 48-bit serial number and an 8-bit check byte. All three are parameters. The check byte can be derived at elaboration time or given directly. The block drives one output that pulls the line low. The line itself, with its pull-up, forms a wired AND outside the block. Every time interval is a count of microseconds scaled by a ticks-per-microsecond parameter.

Top module: `swid_slave`

## Requirements
- R1: A low on the line lasting longer than RESET_US, followed by a release, is a reset. The block then keeps the line released for PRES_WAIT_US and pulls it low for PRES_LEN_US (the presence pulse). Out of system reset the block does not pull.
- R2: A low lasting RESET_US or less is not a reset and produces no presence pulse. A long write-0 slot is still decoded as a data bit.
- R3: After presence, the block reads a command of 8 slots, least significant bit first. Each slot starts on a falling edge of the line and is sampled SAMPLE_US later. A low sample is 0 and a high sample is 1.
- R4: Command 0x33 makes the block send its 64 identifier bits in 64 read slots, least significant bit first. The family code fills bits 7:0, the serial number bits 55:8 and the check byte bits 63:56. To send a 0 the block pulls the line for DRIVE_US after the slot's falling edge. To send a 1 it leaves the line released.
- R5: The check byte is the CRC of bits 55:0 with polynomial x^8+x^5+x^4+1. The register starts at zero and takes the bits least significant first. The same CRC over all 64 bits is therefore zero.
- R6: Any command other than 0x33 or 0xF0, including 0x55 and 0xCC, makes the block stop pulling until the next reset.
- R7: Command 0xF0 starts a search. For each identifier bit, least significant first, the block sends the bit, then sends its complement, then samples the master's chosen bit, using three slots.
- R8: In a search, if the bit written by the master differs from the block's own bit, the block stops pulling until the next reset.
- R9: After the last of the 64 bits of a read or a search, the block stops pulling until the next reset.
- R10: A reset at any point, including in the middle of a read, abandons the transaction and gives a new presence pulse. The command sequence then starts again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| bus_in | input | 1 | Sampled state of the shared line (1 = high) |
| bus_pull | output | 1 | 1 pulls the shared line low; 0 releases it |

## Verification
The bench builds the block with TICKS_PER_US = 2, so each microsecond of bus timing is two clocks. At that scale a whole search of 192 slots and several reset cycles fit in a short run. The serial number has mixed bit values in every byte, so both the true and the complemented search slots are seen driving low. The check byte is derived inside the block, and the bench recomputes it on its own. A 100 µs write-0 low sits close to the 120 µs reset threshold, which tests that boundary without a presence pulse.

// File: rtl/swid_pkg.sv
package swid_pkg;

   localparam int ID_BITS  = 64;
   localparam int FAM_BITS = 8;
   localparam int SER_BITS = 48;

   localparam logic [7:0] CMD_READ_ID = 8'h33;
   localparam logic [7:0] CMD_SEARCH  = 8'hF0;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRES,
      ST_CMD,
      ST_READ,
      ST_SRCH_T,
      ST_SRCH_C,
      ST_SRCH_W,
      ST_MUTE
   } swid_state_e;

   // Eight-stage shift register, taps for x^8 + x^5 + x^4 + 1, input LSB first
   function automatic logic [7:0] swid_check8(input logic [55:0] d);
      logic [7:0] r;
      logic       fb;
      r = '0;
      for (int i = 0; i < 56; i++) begin
         fb = r[0] ^ d[i];
         r  = {fb, r[7], r[6], r[5], r[4] ^ fb, r[3] ^ fb, r[2], r[1]};
      end
      return r;
   endfunction

endpackage

// File: rtl/swid_line_mon.sv
module swid_line_mon #(
   parameter int TICKS_PER_US = 10,
   parameter int RESET_US     = 120,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   input  logic own_pull,
   output logic line_s,
   output logic fall,
   output logic reset_end
);

   localparam int RST_TICKS = RESET_US * TICKS_PER_US;
   localparam int CW        = $clog2(RST_TICKS + 2);
   localparam int MASK_LEN  = SYNC_STAGES + 2;
   localparam logic [CW-1:0] CNT_SAT = CW'(RST_TICKS + 1);
   localparam logic [CW-1:0] CNT_THR = CW'(RST_TICKS);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("swid_line_mon: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic [MASK_LEN-1:0]    hist_q;
   logic [CW-1:0]          low_q;
   logic                   masked;

   assign line_s = sync_q[SYNC_STAGES-1];
   assign masked = own_pull | (|hist_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
         hist_q <= '0;
         low_q  <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], line_raw};
         prev_q <= line_s;
         hist_q <= {hist_q[MASK_LEN-2:0], own_pull};
         if (line_s || masked)
            low_q <= '0;
         else if (low_q != CNT_SAT)
            low_q <= low_q + 1'b1;
      end
   end

   assign fall      = prev_q & ~line_s;
   assign reset_end = ~prev_q & line_s & (low_q > CNT_THR);

endmodule

// File: rtl/swid_slot_timer.sv
module swid_slot_timer #(
   parameter int TICKS_PER_US = 10,
   parameter int SAMPLE_US    = 30,
   parameter int DRIVE_US     = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic sample,
   output logic drive_win
);

   localparam int SMP_T = SAMPLE_US * TICKS_PER_US;
   localparam int DRV_T = DRIVE_US * TICKS_PER_US;
   localparam int END_T = (SMP_T > DRV_T) ? SMP_T : DRV_T;
   localparam int CW    = $clog2(END_T + 1);

   if (SMP_T < 1 || DRV_T < 1) begin : g_bad_slot
      $error("swid_slot_timer: sample and drive windows must be non-zero");
   end

   logic          busy_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end
      end else if (cnt_q == CW'(END_T)) begin
         busy_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign sample    = busy_q && (cnt_q == CW'(SMP_T));
   assign drive_win = busy_q && (cnt_q < CW'(DRV_T));

endmodule

// File: rtl/swid_presence.sv
module swid_presence #(
   parameter int TICKS_PER_US = 10,
   parameter int WAIT_US      = 30,
   parameter int LEN_US       = 120
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic pull,
   output logic done
);

   localparam int WT = WAIT_US * TICKS_PER_US;
   localparam int LT = LEN_US * TICKS_PER_US;
   localparam int CW = $clog2(((WT > LT) ? WT : LT) + 1);

   if (WT < 1 || LT < 1) begin : g_bad_pres
      $error("swid_presence: wait and pulse lengths must be non-zero");
   end

   typedef enum logic [1:0] {P_OFF, P_WAIT, P_LOW} pres_phase_e;

   pres_phase_e   phase_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= P_OFF;
         cnt_q   <= '0;
      end else if (start) begin
         phase_q <= P_WAIT;
         cnt_q   <= '0;
      end else begin
         case (phase_q)
            P_WAIT: begin
               if (cnt_q == CW'(WT - 1)) begin
                  phase_q <= P_LOW;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            P_LOW: begin
               if (cnt_q == CW'(LT - 1)) begin
                  phase_q <= P_OFF;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: cnt_q <= '0;
         endcase
      end
   end

   assign pull = (phase_q == P_LOW);
   assign done = (phase_q == P_LOW) && (cnt_q == CW'(LT - 1));

endmodule

// File: rtl/swid_id_rom.sv
module swid_id_rom
   import swid_pkg::*;
#(
   parameter logic [FAM_BITS-1:0] FAMILY     = 8'h01,
   parameter logic [SER_BITS-1:0] SERIAL     = 48'h0,
   parameter bit                  AUTO_CHECK = 1'b1,
   parameter logic [7:0]          CHECK_BYTE = 8'h00
) (
   input  logic [$clog2(ID_BITS)-1:0] idx,
   output logic                       id_bit
);

   logic [ID_BITS-1:0] id_word;

   if (AUTO_CHECK) begin : g_auto_chk
      localparam logic [7:0] CHK = swid_check8({SERIAL, FAMILY});
      assign id_word = {CHK, SERIAL, FAMILY};
   end else begin : g_given_chk
      assign id_word = {CHECK_BYTE, SERIAL, FAMILY};
   end

   assign id_bit = id_word[idx];

endmodule

// File: rtl/swid_slave.sv
module swid_slave
   import swid_pkg::*;
#(
   parameter int                  TICKS_PER_US = 10,
   parameter logic [FAM_BITS-1:0] FAMILY       = 8'h01,
   parameter logic [SER_BITS-1:0] SERIAL       = 48'h0000_0000_0001,
   parameter bit                  AUTO_CHECK   = 1'b1,
   parameter logic [7:0]          CHECK_BYTE   = 8'h00,
   parameter int                  RESET_US     = 120,
   parameter int                  SAMPLE_US    = 30,
   parameter int                  DRIVE_US     = 30,
   parameter int                  PRES_WAIT_US = 30,
   parameter int                  PRES_LEN_US  = 120,
   parameter int                  SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_in,
   output logic bus_pull
);

   localparam int IDX_W = $clog2(ID_BITS);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_BITS - 1);
   localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(7);
   localparam int LONGEST_US = (PRES_LEN_US > DRIVE_US) ? PRES_LEN_US : DRIVE_US;
   localparam logic [31:0] PULL_MAX = 32'(LONGEST_US * TICKS_PER_US + 2);

   if (TICKS_PER_US < 1) begin : g_bad_tpu
      $error("swid_slave: TICKS_PER_US must be at least 1");
   end
   if (SAMPLE_US >= RESET_US) begin : g_bad_smp
      $error("swid_slave: SAMPLE_US must be below RESET_US");
   end

   swid_state_e      state_q;
   logic [IDX_W-1:0] idx_q;
   logic [7:0]       cmd_q;
   logic [7:0]       cmd_nxt;
   logic             pull_q;

   logic line_s, fall, reset_end;
   logic slot_start, slot_sample, drive_win;
   logic pres_pull, pres_done;
   logic id_bit, tx_on, tx_val, slot_state;

   swid_line_mon #(
      .TICKS_PER_US(TICKS_PER_US),
      .RESET_US    (RESET_US),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_raw (bus_in),
      .own_pull (pull_q),
      .line_s   (line_s),
      .fall     (fall),
      .reset_end(reset_end)
   );

   swid_slot_timer #(
      .TICKS_PER_US(TICKS_PER_US),
      .SAMPLE_US   (SAMPLE_US),
      .DRIVE_US    (DRIVE_US)
   ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (slot_start),
      .sample   (slot_sample),
      .drive_win(drive_win)
   );

   swid_presence #(
      .TICKS_PER_US(TICKS_PER_US),
      .WAIT_US     (PRES_WAIT_US),
      .LEN_US      (PRES_LEN_US)
   ) u_pres (
      .clk  (clk),
      .rst_n(rst_n),
      .start(reset_end),
      .pull (pres_pull),
      .done (pres_done)
   );

   swid_id_rom #(
      .FAMILY    (FAMILY),
      .SERIAL    (SERIAL),
      .AUTO_CHECK(AUTO_CHECK),
      .CHECK_BYTE(CHECK_BYTE)
   ) u_rom (
      .idx   (idx_q),
      .id_bit(id_bit)
   );

   assign slot_state = (state_q == ST_CMD)    || (state_q == ST_READ) ||
                       (state_q == ST_SRCH_T) || (state_q == ST_SRCH_C) ||
                       (state_q == ST_SRCH_W);
   assign slot_start = fall && slot_state;
   assign tx_on      = (state_q == ST_READ) || (state_q == ST_SRCH_T) ||
                       (state_q == ST_SRCH_C);
   assign tx_val     = (state_q == ST_SRCH_C) ? ~id_bit : id_bit;
   assign cmd_nxt    = {line_s, cmd_q[7:1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         cmd_q   <= '0;
      end else if (reset_end) begin
         state_q <= ST_PRES;
         idx_q   <= '0;
      end else begin
         case (state_q)
            ST_PRES: begin
               if (pres_done) begin
                  state_q <= ST_CMD;
                  idx_q   <= '0;
               end
            end
            ST_CMD: begin
               if (slot_sample) begin
                  cmd_q <= cmd_nxt;
                  if (idx_q == CMD_LAST) begin
                     idx_q <= '0;
                     case (cmd_nxt)
                        CMD_READ_ID: state_q <= ST_READ;
                        CMD_SEARCH:  state_q <= ST_SRCH_T;
                        default:     state_q <= ST_MUTE;
                     endcase
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            ST_READ: begin
               if (slot_sample) begin
                  if (idx_q == IDX_LAST) state_q <= ST_MUTE;
                  else idx_q <= idx_q + 1'b1;
               end
            end
            ST_SRCH_T: if (slot_sample) state_q <= ST_SRCH_C;
            ST_SRCH_C: if (slot_sample) state_q <= ST_SRCH_W;
            ST_SRCH_W: begin
               if (slot_sample) begin
                  if (line_s != id_bit) begin
                     state_q <= ST_MUTE;
                  end else if (idx_q == IDX_LAST) begin
                     state_q <= ST_MUTE;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= ST_SRCH_T;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pull_q <= 1'b0;
      else        pull_q <= pres_pull | (tx_on && drive_win && !tx_val);
   end

   assign bus_pull = pull_q;

endmodule

// File: rtl/swid_slave_chk.sv
module swid_slave_chk
   import swid_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input swid_state_e state,
   input logic        reset_end,
   input logic        sample,
   input logic        rx_bit,
   input logic        id_bit,
   input logic [5:0]  bit_idx,
   input logic        bus_pull,
   input logic [31:0] pull_limit
);

   logic [31:0] pull_run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        pull_run_q <= '0;
      else if (bus_pull) pull_run_q <= pull_run_q + 1'b1;
      else               pull_run_q <= '0;
   end

   assert_presence_on_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      reset_end |=> state == ST_PRES);

   assert_pull_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pull_run_q <= pull_limit);

   assert_mute_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MUTE && $past(state) == ST_MUTE) |-> !bus_pull);

   assert_cmd_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CMD && $past(state) == ST_CMD) |-> !bus_pull);

   assert_mismatch_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SRCH_W && sample && rx_bit != id_bit && !reset_end) |=> state == ST_MUTE);

   assert_read_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_READ && sample && bit_idx == 6'd63 && !reset_end) |=> state == ST_MUTE);

endmodule

bind swid_slave swid_slave_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .state     (state_q),
   .reset_end (reset_end),
   .sample    (slot_sample),
   .rx_bit    (line_s),
   .id_bit    (id_bit),
   .bit_idx   (idx_q),
   .bus_pull  (bus_pull),
   .pull_limit(PULL_MAX)
);

// File: tb/swid_slave_tb_top.sv
module swid_slave_tb_top;

   localparam int          TPU = 2;
   localparam logic [7:0]  FAM = 8'h01;
   localparam logic [47:0] SER = 48'h6BE1_960F_3CA5;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n  = 1'b0;
   logic m_pull = 1'b0;
   logic s_pull;
   logic bus_line;
   assign bus_line = ~(m_pull | s_pull);

   swid_slave #(
      .TICKS_PER_US(TPU),
      .FAMILY      (FAM),
      .SERIAL      (SER)
   ) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_in  (bus_line),
      .bus_pull(s_pull)
   );

   int checks = 0;
   int fails  = 0;
   logic finished = 1'b0;

   logic  exp_q[$];
   string tag_q[$];
   logic  samp;
   event  sample_ev;
   logic [63:0] cap;
   int cap_n;
   logic [63:0] id_exp;

   function automatic logic [7:0] ref_crc(input logic [63:0] d, input int n);
      logic [7:0] c;
      logic fb;
      c = 8'h00;
      for (int i = 0; i < n; i++) begin
         fb = c[0] ^ d[i];
         c  = c >> 1;
         if (fb) c = c ^ 8'h8C;
      end
      return c;
   endfunction

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops the expected bit for every read slot sample
   initial begin
      forever begin
         @(sample_ev);
         if (exp_q.size() == 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard actual=%0b expected=none", samp);
         end else begin
            chk({7'd0, samp}, {7'd0, exp_q.pop_front()}, tag_q.pop_front());
         end
      end
   end

   task automatic us(input int n);
      repeat (n * TPU) @(negedge clk);
   endtask

   task automatic bus_reset(input string tag);
      m_pull = 1'b1;
      us(500);
      m_pull = 1'b0;
      us(10);
      chk({7'd0, bus_line}, 8'd1, {tag, " no early presence"});
      us(50);
      chk({7'd0, bus_line}, 8'd0, {tag, " presence low"});
      us(180);
      chk({7'd0, bus_line}, 8'd1, {tag, " presence ended"});
      us(20);
   endtask

   task automatic write_bit(input logic b);
      m_pull = 1'b1;
      if (b) us(6); else us(60);
      m_pull = 1'b0;
      if (b) us(64); else us(10);
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) write_bit(v[i]);
   endtask

   task automatic read_expect(input logic e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      m_pull = 1'b1;
      us(2);
      m_pull = 1'b0;
      us(13);
      samp = bus_line;
      if (cap_n < 64) cap[cap_n] = bus_line;
      cap_n++;
      ->sample_ev;
      us(55);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog all-R actual=timeout expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      id_exp = {8'h00, SER, FAM};
      id_exp[63:56] = ref_crc(id_exp, 56);

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      us(5);
      chk({7'd0, s_pull}, 8'd0, "R1 reset state no pull");

      // R1 / R3 / R4 / R5 / R9: full read
      bus_reset("R1");
      send_byte(8'h33);
      cap_n = 0;
      for (int i = 0; i < 64; i++) read_expect(id_exp[i], $sformatf("R4 read bit %0d", i));
      chk(cap[63:56], ref_crc(cap, 56), "R5 check byte");
      chk(ref_crc(cap, 64), 8'h00, "R5 crc over all 64");
      for (int i = 0; i < 8; i++) read_expect(1'b1, "R9 silent after read");

      // R6: unsupported commands
      bus_reset("R6");
      send_byte(8'h55);
      for (int i = 0; i < 8; i++) read_expect(1'b1, "R6 silent after 0x55");
      bus_reset("R6");
      send_byte(8'hCC);
      for (int i = 0; i < 8; i++) read_expect(1'b1, "R6 silent after 0xCC");

      // R7 / R9: complete matching search
      bus_reset("R7");
      send_byte(8'hF0);
      for (int i = 0; i < 64; i++) begin
         read_expect(id_exp[i], $sformatf("R7 true bit %0d", i));
         read_expect(~id_exp[i], $sformatf("R7 complement bit %0d", i));
         write_bit(id_exp[i]);
      end
      for (int i = 0; i < 4; i++) read_expect(1'b1, "R9 silent after search");

      // R8: mismatch at bit 5
      bus_reset("R8");
      send_byte(8'hF0);
      for (int i = 0; i < 6; i++) begin
         read_expect(id_exp[i], "R8 pre-mismatch true");
         read_expect(~id_exp[i], "R8 pre-mismatch complement");
         write_bit(i == 5 ? ~id_exp[i] : id_exp[i]);
      end
      for (int i = 0; i < 3; i++) begin
         read_expect(1'b1, "R8 dropped true slot");
         read_expect(1'b1, "R8 dropped complement slot");
         write_bit(id_exp[6 + i]);
      end

      // R10: reset in the middle of a read
      bus_reset("R10");
      send_byte(8'h33);
      for (int i = 0; i < 10; i++) read_expect(id_exp[i], "R10 partial read");
      bus_reset("R10");
      send_byte(8'h33);
      for (int i = 0; i < 8; i++) read_expect(id_exp[i], "R10 read restarts at family");

      // R2: a 100 us low is a data 0, not a reset
      bus_reset("R2");
      m_pull = 1'b1;
      us(100);
      m_pull = 1'b0;
      us(60);
      chk({7'd0, bus_line}, 8'd1, "R2 no presence after 100us low");
      us(10);
      for (int i = 1; i < 8; i++) write_bit(8'hF0 >> i);
      read_expect(id_exp[0], "R2 search started after long zero");
      read_expect(~id_exp[0], "R2 search complement");

      us(20);
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule